// File: doc/BRIEF.md
# Quad DAC Serial Command Front End

This block is the digital input stage of a four-channel, 8-bit digital-to-analog converter. It watches four slow, asynchronous pins: a serial clock, a serial data line, a latch strobe and an update strobe. It brings each pin into a fast system clock domain through a two-flop synchronizer and detects falling edges there. On every falling edge of the serial clock it shifts one data bit into an 11-bit command word, most significant bit first.

A complete command carries a 2-bit channel number, a gain bit and an 8-bit code. A falling edge on the latch strobe writes a complete command into the input register of the addressed channel. A falling edge on the update strobe copies all four input registers into the output registers together. The output registers drive the converters. While the update strobe is held low, a latched command goes straight through to the addressed output register as well. Each accepted latch raises a one-cycle pulse that carries the channel index.

Top module: `qdac_front`

## Requirements
- R1: While reset is asserted and right after it, all four output codes are 0, all four gain flags are 0 (times one) and the latch pulse is low.
- R2: Bits are taken on serial-clock falling edges, first bit received as the command's bit 10. Bits 10:9 are the channel (0..3 = A..D), bit 8 is the gain (0 = times one, 1 = times two) and bits 7:0 are the code.
- R3: A latch-strobe falling edge after 11 or more bits writes only the addressed channel's input register. With the update strobe high, no output register changes.
- R4: An update-strobe falling edge copies all four input registers (code and gain) into the output registers in the same cycle.
- R5: A latch-strobe falling edge after fewer than 11 bits is ignored: no pulse is raised and no input register changes.
- R6: Every latch-strobe falling edge clears the bit count and the shift register, so the next command is assembled from fresh bits.
- R7: While the update strobe is held low, an accepted latch also writes the addressed channel's output register.
- R8: Each accepted latch raises latch_vld_o for exactly one cycle, with latch_ch_o giving the channel. No other event raises it.
- R9: When more than 11 bits arrive before a latch, the last 11 bits received form the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| sdi_i | input | 1 | Serial data pin (asynchronous) |
| ld_n_i | input | 1 | Latch strobe, active on falling edge |
| upd_n_i | input | 1 | Update strobe, active on falling edge, pass-through while low |
| code_o | output | 4x8 | Output register codes, channel index major |
| gain_o | output | 4 | Output register gain flags |
| latch_vld_o | output | 1 | One-cycle pulse per accepted latch |
| latch_ch_o | output | 2 | Channel of the accepted latch |

## Verification
The assertions assume that every pin level lasts at least two system clock cycles. They also assume that the data line is stable before the serial clock falls, so that the synchronized data bit is already valid when the edge is seen. The stimulus holds every pin level for four system cycles and changes data only while the serial clock is high. Latch and update strobes are applied only while the serial clock is idle, and each strobe level is held long enough that two of its edges never meet inside the synchronizers.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // Pin positions in the synchronizer vector
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_SDI  = 1;
  localparam int unsigned PIN_LD   = 2;
  localparam int unsigned PIN_UPD  = 3;
  localparam int unsigned NUM_PINS = 4;

  // Default geometry
  localparam int unsigned DEF_CHANNELS = 4;
  localparam int unsigned DEF_CODE_W   = 8;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;
  logic [W-1:0] meta_d, lvl_d, prev_d;

  always_comb begin
    meta_d = pin_i;
    lvl_d  = meta_q;
    prev_d = lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign fall_o = prev_q & ~lvl_q;
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int unsigned FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               bit_i,
  input  logic               clr_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               full_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               full;

  assign full = (cnt_q == CNT_MAX);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (shift_en_i) begin
      sr_d  = {sr_q[FRAME_W-2:0], bit_i};
      cnt_d = full ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame_o = sr_q;
  assign full_o  = full;
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned SEL_W  = $clog2(NCH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SEL_W-1:0]             wr_sel_i,
  input  logic                         wr_gain_i,
  input  logic [CODE_W-1:0]            wr_code_i,
  input  logic                         pass_i,
  input  logic                         xfer_i,
  output logic [NCH-1:0][CODE_W-1:0]   in_code_o,
  output logic [NCH-1:0]               in_gain_o,
  output logic [NCH-1:0][CODE_W-1:0]   out_code_o,
  output logic [NCH-1:0]               out_gain_o,
  output logic                         latch_vld_o,
  output logic [SEL_W-1:0]             latch_ch_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] in_c_q, in_c_d, out_c_q, out_c_d;
    logic              in_g_q, in_g_d, out_g_q, out_g_d;

    assign hit = wr_en_i && (wr_sel_i == SEL_W'(c));

    always_comb begin
      in_c_d  = in_c_q;
      in_g_d  = in_g_q;
      out_c_d = out_c_q;
      out_g_d = out_g_q;
      if (hit) begin
        in_c_d = wr_code_i;
        in_g_d = wr_gain_i;
      end
      if (hit && (pass_i || xfer_i)) begin
        out_c_d = wr_code_i;
        out_g_d = wr_gain_i;
      end else if (xfer_i) begin
        out_c_d = in_c_q;
        out_g_d = in_g_q;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_c_q  <= '0;
        in_g_q  <= 1'b0;
        out_c_q <= '0;
        out_g_q <= 1'b0;
      end else begin
        in_c_q  <= in_c_d;
        in_g_q  <= in_g_d;
        out_c_q <= out_c_d;
        out_g_q <= out_g_d;
      end
    end

    assign in_code_o[c]  = in_c_q;
    assign in_gain_o[c]  = in_g_q;
    assign out_code_o[c] = out_c_q;
    assign out_gain_o[c] = out_g_q;
  end

  logic             vld_q, vld_d;
  logic [SEL_W-1:0] ch_q, ch_d;

  always_comb begin
    vld_d = wr_en_i;
    ch_d  = wr_en_i ? wr_sel_i : ch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ch_q  <= '0;
    end else begin
      vld_q <= vld_d;
      ch_q  <= ch_d;
    end
  end

  assign latch_vld_o = vld_q;
  assign latch_ch_o  = ch_q;
endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int unsigned NCH    = DEF_CHANNELS,
  parameter int unsigned CODE_W = DEF_CODE_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  input  logic                       ld_n_i,
  input  logic                       upd_n_i,
  output logic [NCH-1:0][CODE_W-1:0] code_o,
  output logic [NCH-1:0]             gain_o,
  output logic                       latch_vld_o,
  output logic [$clog2(NCH)-1:0]     latch_ch_o
);
  localparam int unsigned SEL_W   = $clog2(NCH);
  localparam int unsigned FRAME_W = SEL_W + 1 + CODE_W;

  logic [NUM_PINS-1:0] pins, lvl, fall;
  logic [FRAME_W-1:0]  frame;
  logic                frame_full, ld_fall, upd_fall, upd_low, wr_en;
  logic [NCH-1:0][CODE_W-1:0] in_code;
  logic [NCH-1:0]             in_gain;

  always_comb begin
    pins          = '0;
    pins[PIN_SCK] = sck_i;
    pins[PIN_SDI] = sdi_i;
    pins[PIN_LD]  = ld_n_i;
    pins[PIN_UPD] = upd_n_i;
  end

  qdac_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pins),
    .lvl_o (lvl),
    .fall_o(fall)
  );

  assign ld_fall  = fall[PIN_LD];
  assign upd_fall = fall[PIN_UPD];
  assign upd_low  = ~lvl[PIN_UPD];

  qdac_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(fall[PIN_SCK] && !ld_fall),
    .bit_i     (lvl[PIN_SDI]),
    .clr_i     (ld_fall),
    .frame_o   (frame),
    .full_o    (frame_full)
  );

  assign wr_en = ld_fall && frame_full;

  qdac_bank #(.NCH(NCH), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_sel_i   (frame[FRAME_W-1 -: SEL_W]),
    .wr_gain_i  (frame[CODE_W]),
    .wr_code_i  (frame[CODE_W-1:0]),
    .pass_i     (upd_low),
    .xfer_i     (upd_fall),
    .in_code_o  (in_code),
    .in_gain_o  (in_gain),
    .out_code_o (code_o),
    .out_gain_o (gain_o),
    .latch_vld_o(latch_vld_o),
    .latch_ch_o (latch_ch_o)
  );
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NCH-1:0][CODE_W-1:0] code_o,
  input logic [NCH-1:0]             gain_o,
  input logic                       latch_vld_o,
  input logic                       ld_fall,
  input logic                       frame_full,
  input logic                       upd_fall,
  input logic                       upd_low,
  input logic [NCH-1:0][CODE_W-1:0] in_code,
  input logic [NCH-1:0]             in_gain
);
  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (code_o == '0 && gain_o == '0 && !latch_vld_o);
    end
  end

  // R3
  outputs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_low |=> ($stable(code_o) && $stable(gain_o)));

  // R4
  update_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_fall && !(ld_fall && frame_full)) |=>
      (code_o == $past(in_code) && gain_o == $past(in_gain)));

  // R5
  short_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fall && !frame_full) |=> !latch_vld_o);

  // R8
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_vld_o |=> !latch_vld_o);

  // R8
  pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fall && frame_full) |=> latch_vld_o);
endmodule

bind qdac_front qdac_front_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .code_o     (code_o),
  .gain_o     (gain_o),
  .latch_vld_o(latch_vld_o),
  .ld_fall    (ld_fall),
  .frame_full (frame_full),
  .upd_fall   (upd_fall),
  .upd_low    (upd_low),
  .in_code    (in_code),
  .in_gain    (in_gain)
);

// File: tb/qdac_front_test.sv
module qdac_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, ld_n = 1'b1, upd_n = 1'b1;
  logic [3:0][7:0] code;
  logic [3:0]      gain;
  logic            lvld;
  logic [1:0]      lch;

  int checks = 0;
  int fails  = 0;

  logic [7:0] ein_c [4];
  logic       ein_g [4];
  logic [7:0] eout_c[4];
  logic       eout_g[4];
  logic       upd_is_low = 1'b0;
  int         exp_q[$];

  always #2.5 clk = ~clk;

  qdac_front uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi),
    .ld_n_i(ld_n), .upd_n_i(upd_n), .code_o(code), .gain_o(gain),
    .latch_vld_o(lvld), .latch_ch_o(lch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      sck = 1'b1;
      wait_cyc(4);
      sck = 1'b0;
      wait_cyc(4);
    end
  endtask

  task automatic strobe_load(input bit accept, input int ch, input bit g, input logic [7:0] c);
    if (accept) begin
      exp_q.push_back(ch);
      ein_c[ch] = c;
      ein_g[ch] = g;
      if (upd_is_low) begin
        eout_c[ch] = c;
        eout_g[ch] = g;
      end
    end
    ld_n = 1'b0;
    wait_cyc(4);
    ld_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic send_cmd(input int ch, input bit g, input logic [7:0] c);
    shift_bits({5'b0, 2'(ch), g, c}, 11);
    strobe_load(1'b1, ch, g, c);
  endtask

  task automatic update_fall;
    upd_n = 1'b0;
    upd_is_low = 1'b1;
    for (int k = 0; k < 4; k++) begin
      eout_c[k] = ein_c[k];
      eout_g[k] = ein_g[k];
    end
    wait_cyc(4);
  endtask

  task automatic update_rise;
    upd_n = 1'b1;
    upd_is_low = 1'b0;
    wait_cyc(4);
  endtask

  task automatic check_outs(input string tag);
    for (int k = 0; k < 4; k++) begin
      check(code[k] == eout_c[k], tag, int'(code[k]), int'(eout_c[k]));
      check(gain[k] == eout_g[k], tag, int'(gain[k]), int'(eout_g[k]));
    end
  endtask

  // Scoreboard monitor for latch pulses (R8)
  always @(negedge clk) begin
    if (rst_n && lvld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected latch pulse", int'(lch), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(lch) == e, "R8 latch channel", int'(lch), e);
      end
    end
  end

  // R8 pulse width: one cycle
  logic lvld_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && lvld && lvld_prev) check(1'b0, "R8 pulse longer than one cycle", 1, 0);
    lvld_prev = lvld;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      ein_c[k] = '0; ein_g[k] = 1'b0; eout_c[k] = '0; eout_g[k] = 1'b0;
    end
    wait_cyc(3);
    // R1 reset state
    check_outs("R1 reset outputs");
    check(lvld == 1'b0, "R1 reset pulse", int'(lvld), 0);
    rst_n = 1'b1;
    wait_cyc(4);
    check_outs("R1 after release");

    // R2 R3: command to channel C, gain x2, code A5; outputs stay put
    send_cmd(2, 1'b1, 8'hA5);
    check_outs("R3 outputs unchanged before update");
    // R4: update copies input registers
    update_fall();
    check_outs("R2 R4 channel C after update");
    update_rise();

    // R4: all four channels, distinct patterns
    send_cmd(0, 1'b0, 8'h01);
    send_cmd(1, 1'b1, 8'h80);
    send_cmd(3, 1'b0, 8'hFF);
    send_cmd(2, 1'b0, 8'h3C);
    check_outs("R3 no output change with update high");
    update_fall();
    check_outs("R4 all channels");
    update_rise();

    // R5: short frame ignored, R6: next frame assembled fresh
    shift_bits(16'h07F, 7);
    strobe_load(1'b0, 0, 1'b0, 8'h00);
    check(exp_q.size() == 0, "R5 no pulse for short frame", exp_q.size(), 0);
    update_fall();
    check_outs("R5 input registers unchanged");
    update_rise();
    shift_bits(16'h3FF, 10);
    strobe_load(1'b0, 0, 1'b0, 8'h00);
    send_cmd(1, 1'b0, 8'h5A);
    update_fall();
    check_outs("R6 fresh frame after cleared short frame");

    // R7: update held low, latch goes straight through
    send_cmd(3, 1'b1, 8'h12);
    check_outs("R7 pass-through while update low");
    send_cmd(0, 1'b1, 8'hC3);
    check_outs("R7 second pass-through");
    update_rise();

    // R9: 13 bits, last 11 form the command
    shift_bits({3'b0, 2'b11, 2'b01, 1'b0, 8'h99}, 13);
    strobe_load(1'b1, 1, 1'b0, 8'h99);
    check_outs("R9 outputs unchanged before update");
    update_fall();
    check_outs("R9 trailing eleven bits used");
    update_rise();

    wait_cyc(4);
    check(exp_q.size() == 0, "R8 all expected pulses seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule